// File: doc/BRIEF.md
# Serial EEPROM Slave with Write Protection Zones

This block is the slave side of a four-wire SPI link in mode 0. It sits in front of a 4 KiB byte-wide storage array. In this design the array is an ordinary register file that stands in for nonvolatile cells. A host drives chip select low and shifts in a one-byte instruction. Depending on that instruction, the host then shifts in a 16-bit address, data bytes or a status byte, or it shifts data out. The status byte reports five things: a busy flag, a write-enable flag, a two-bit protection code and two spare selector bits. The spare bits are stored and read back but control nothing.

Every write must first be armed with a separate enable instruction. Page writes are collected in a 32-byte buffer. They are applied only when chip select rises exactly on a byte boundary. The buffer is then copied into the array over a fixed busy window, and any byte that falls inside the protected zone is dropped. Reads stream out from any start address for as long as chip select stays low, and the address wraps from the top of the array back to zero.

The serial inputs are assumed to be already synchronous to `clk`. Each phase of SCK must last at least four `clk` cycles.

Top module: `spi_ee_top`

## Requirements
- R1: After reset, the status byte reads 0x00, and `so_oe` is low whenever `cs_n` is high.
- R2: Instruction 0x06 sets the write-enable flag (status bit 1). Instruction 0x04 clears it.
- R3: Instruction 0x01 followed by one byte copies bits 5:2 of that byte into the status byte, where bits 3:2 are the protection code and bits 5:4 are the spare selector bits. This happens only if write enable was set, and the write-enable flag then clears. Without write enable the status byte is unchanged. Bits 7:6 always read 0.
- R4: Instruction 0x03 followed by a 16-bit address returns array bytes MSB first, starting at that address and incrementing by one per byte. The upper four address bits are ignored.
- R5: A read that passes address 0xFFF continues at 0x000.
- R6: Instruction 0x02 followed by an address and data bytes stores those bytes only if write enable was set. Otherwise the array is unchanged.
- R7: During one write, the address advances only within its 32-byte page, so the byte after offset 31 lands at offset 0 of the same page.
- R8: A write takes effect only if `cs_n` rises after a whole number of bytes. If `cs_n` rises in the middle of a byte, nothing is written and the write-enable flag is left as it was.
- R9: Protection code 00 protects nothing, 01 protects 0xC00–0xFFF, 10 protects 0x800–0xFFF and 11 protects the whole array. Writes to protected bytes are silently discarded.
- R10: After each accepted array or status write, the busy flag (status bit 0) stays set for BUSY_CYCLES clocks. While it is set, every instruction except 0x05 is ignored, and the write-enable flag is already clear.
- R11: `si` is sampled on the rising edge of `sck`, and `so` changes on the falling edge, MSB first. Instruction 0x05 returns the live status byte for as long as bytes keep being clocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, idle low |
| si | input | 1 | Serial data into the slave |
| so | output | 1 | Serial data out of the slave |
| so_oe | output | 1 | Output enable for `so`; low models high impedance |

## Verification
The assertions rely on three assumptions about the inputs. `cs_n`, `sck` and `si` change only in step with `clk`. Each SCK phase is long enough for a synchronous array read to finish before the next falling edge. A new page write never begins while the busy flag is set. The bench meets these assumptions in three ways. It drives every serial input on the falling clock edge and holds each SCK phase for four clocks. It waits on the busy flag, polled through status reads, before it issues the next write. The only instruction it sends on purpose inside a busy window is a write-enable, and the design must ignore it.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_PROG = 8'h02;

  typedef enum logic [2:0] {
    ST_OPC, ST_AHI, ST_ALO, ST_RD, ST_WR, ST_SRW, ST_STAT, ST_SKIP
  } ee_st_e;

  // zone code against the two top address bits
  function automatic logic zone_locked(input logic [1:0] code, input logic [1:0] top2);
    case (code)
      2'b00:   return 1'b0;
      2'b01:   return (top2 == 2'b11);
      2'b10:   return top2[1];
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/spi_ee_shift.sv
module spi_ee_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_s,
  input  logic       sck_s,
  input  logic       si_s,
  input  logic [7:0] tx_byte,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic       on_boundary,
  output logic       so_bit
);
  logic       sck_d, sck_d_nx;
  logic [2:0] bitcnt, bitcnt_nx;
  logic [6:0] rx_sr, rx_sr_nx;
  logic [7:0] tx_sr, tx_sr_nx;
  logic       rise, fall;

  assign rise        = ~cs_s & sck_s & ~sck_d;
  assign fall        = ~cs_s & ~sck_s & sck_d;
  assign rx_valid    = rise && (bitcnt == 3'd7);
  assign rx_byte     = {rx_sr, si_s};
  assign on_boundary = (bitcnt == 3'd0);
  assign so_bit      = tx_sr[7];

  always_comb begin
    sck_d_nx  = sck_s;
    bitcnt_nx = bitcnt;
    rx_sr_nx  = rx_sr;
    tx_sr_nx  = tx_sr;
    if (cs_s) bitcnt_nx = 3'd0;
    else if (rise) bitcnt_nx = bitcnt + 3'd1;
    if (rise) rx_sr_nx = {rx_sr[5:0], si_s};
    if (fall) tx_sr_nx = (bitcnt == 3'd0) ? tx_byte : {tx_sr[6:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d  <= 1'b0;
      bitcnt <= 3'd0;
      rx_sr  <= 7'd0;
      tx_sr  <= 8'd0;
    end else begin
      sck_d  <= sck_d_nx;
      bitcnt <= bitcnt_nx;
      rx_sr  <= rx_sr_nx;
      tx_sr  <= tx_sr_nx;
    end
  end

  a_r11_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (bitcnt == 3'd0));
endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl
  import spi_ee_pkg::*;
#(
  parameter int AW          = 12,
  parameter int PW          = 5,
  parameter int BUSY_CYCLES = 600
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          on_boundary,
  output logic [7:0]    tx_byte,
  output logic [AW-1:0] mem_raddr,
  input  logic [7:0]    mem_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata
);
  localparam int PAGE = 1 << PW;
  localparam int BW   = $clog2(BUSY_CYCLES + 1);

  ee_st_e        st, st_nx;
  logic [AW-1:0] addr, addr_nx;
  logic          is_wr, is_wr_nx, wel, wel_nx, cs_d;
  logic [1:0]    zone, zone_nx, spare, spare_nx;
  logic [3:0]    sr_new, sr_new_nx;
  logic          pend_pg, pend_pg_nx, pend_sr, pend_sr_nx;
  logic [PAGE-1:0] pvld, pvld_nx;
  logic [BW-1:0] busy_cnt, busy_cnt_nx;
  logic [PW-1:0] cidx, cidx_nx;
  logic          cmt_on, cmt_on_nx, buf_we, wip, cs_rise;
  logic [7:0]    pbuf [PAGE];

  assign wip       = (busy_cnt != '0);
  assign cs_rise   = cs_s & ~cs_d;
  assign tx_byte   = (st == ST_RD) ? mem_rdata : {2'b00, spare, zone, wel, wip};
  assign mem_raddr = addr;
  assign mem_waddr = {addr[AW-1:PW], cidx};
  assign mem_wdata = pbuf[cidx];
  assign mem_we    = cmt_on && pvld[cidx] && !zone_locked(zone, mem_waddr[AW-1 -: 2]);

  always_comb begin
    st_nx = st; addr_nx = addr; is_wr_nx = is_wr; wel_nx = wel;
    zone_nx = zone; spare_nx = spare; sr_new_nx = sr_new;
    pend_pg_nx = pend_pg; pend_sr_nx = pend_sr; pvld_nx = pvld;
    busy_cnt_nx = busy_cnt; cidx_nx = cidx; cmt_on_nx = cmt_on; buf_we = 1'b0;
    if (wip) busy_cnt_nx = busy_cnt - BW'(1);
    if (cmt_on) begin
      cidx_nx = cidx + PW'(1);
      if (&cidx) cmt_on_nx = 1'b0;
    end
    if (cs_s) begin
      st_nx = ST_OPC; pend_pg_nx = 1'b0; pend_sr_nx = 1'b0;
      if (cs_rise && on_boundary && (pend_pg || pend_sr)) begin
        wel_nx = 1'b0;
        busy_cnt_nx = BW'(BUSY_CYCLES);
        if (pend_pg) begin cmt_on_nx = 1'b1; cidx_nx = '0; end
        if (pend_sr) begin zone_nx = sr_new[1:0]; spare_nx = sr_new[3:2]; end
      end
    end else if (rx_valid) begin
      case (st)
        ST_OPC: begin
          st_nx = ST_SKIP;
          if (rx_byte == OP_RDSR) st_nx = ST_STAT;
          else if (!wip) begin
            case (rx_byte)
              OP_WREN: wel_nx = 1'b1;
              OP_WRDI: wel_nx = 1'b0;
              OP_WRSR: if (wel) st_nx = ST_SRW;
              OP_READ: begin st_nx = ST_AHI; is_wr_nx = 1'b0; end
              OP_PROG: if (wel) begin st_nx = ST_AHI; is_wr_nx = 1'b1; pvld_nx = '0; end
              default: ;
            endcase
          end
        end
        ST_AHI: begin addr_nx[AW-1:8] = rx_byte[AW-9:0]; st_nx = ST_ALO; end
        ST_ALO: begin addr_nx[7:0] = rx_byte; st_nx = is_wr ? ST_WR : ST_RD; end
        ST_RD:  addr_nx = addr + AW'(1);
        ST_WR: begin
          buf_we = 1'b1;
          pvld_nx[addr[PW-1:0]] = 1'b1;
          addr_nx[PW-1:0] = addr[PW-1:0] + PW'(1);
          pend_pg_nx = 1'b1;
        end
        ST_SRW: begin sr_new_nx = rx_byte[5:2]; pend_sr_nx = 1'b1; st_nx = ST_SKIP; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_OPC; addr <= '0; is_wr <= 1'b0; wel <= 1'b0; cs_d <= 1'b1;
      zone <= 2'b00; spare <= 2'b00; sr_new <= 4'd0;
      pend_pg <= 1'b0; pend_sr <= 1'b0; pvld <= '0;
      busy_cnt <= '0; cidx <= '0; cmt_on <= 1'b0;
    end else begin
      st <= st_nx; addr <= addr_nx; is_wr <= is_wr_nx; wel <= wel_nx; cs_d <= cs_s;
      zone <= zone_nx; spare <= spare_nx; sr_new <= sr_new_nx;
      pend_pg <= pend_pg_nx; pend_sr <= pend_sr_nx; pvld <= pvld_nx;
      busy_cnt <= busy_cnt_nx; cidx <= cidx_nx; cmt_on <= cmt_on_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[addr[PW-1:0]] <= rx_byte;
  end

  initial begin
    assert (AW > 8 && AW <= 16) else $error("AW out of range");
    assert (BUSY_CYCLES >= PAGE) else $error("busy window shorter than page");
  end

  a_r10_wel_clear_at_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> !wel);
  a_r10_no_write_state_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> (st != ST_WR && st != ST_SRW));
  a_r9_store_only_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wip);
  a_r3_zone_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && $past(wip)) |-> $stable(zone));
endmodule

// File: rtl/spi_ee_top.sv
module spi_ee_top #(
  parameter int AW          = 12,
  parameter int PW          = 5,
  parameter int BUSY_CYCLES = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic so,
  output logic so_oe
);
  logic [1:0]    rst_q;
  logic          rst_core, cs_s, sck_s, si_s;
  logic          rx_valid, on_boundary;
  logic [7:0]    rx_byte, tx_byte, mem_rdata, mem_wdata;
  logic [AW-1:0] mem_raddr, mem_waddr;
  logic          mem_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_core = rst_q[1];

  always_ff @(posedge clk or negedge rst_core) begin
    if (!rst_core) begin
      cs_s <= 1'b1; sck_s <= 1'b0; si_s <= 1'b0;
    end else begin
      cs_s <= cs_n; sck_s <= sck; si_s <= si;
    end
  end
  assign so_oe = ~cs_s;

  spi_ee_shift u_shift (
    .clk(clk), .rst_n(rst_core), .cs_s(cs_s), .sck_s(sck_s), .si_s(si_s),
    .tx_byte(tx_byte), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .on_boundary(on_boundary), .so_bit(so)
  );

  spi_ee_ctrl #(.AW(AW), .PW(PW), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_core), .cs_s(cs_s), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .on_boundary(on_boundary), .tx_byte(tx_byte),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  spi_ee_array #(.AW(AW)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  a_r1_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_core)
    $rose(cs_n) |=> !so_oe);
endmodule

// File: tb/tb_spi_ee_top.sv
module tb_spi_ee_top;
  logic clk, rst_n, cs_n, sck, si;
  logic so, so_oe;
  int   nchk, nfail;
  bit   finished;
  logic [7:0] st, r0, r1;

  spi_ee_top dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
                  .so(so), .so_oe(so_oe));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // address, data
  localparam logic [23:0] VEC [8] = '{
    24'h0000_3C, 24'h0001_A5, 24'h0FFF_5A, 24'h07FF_C3,
    24'h0800_96, 24'h0BFF_69, 24'h0C00_F0, 24'hF123_0F };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      si = t[i]; tick(4); r[i] = so; sck = 1'b1; tick(4); sck = 1'b0;
    end
  endtask

  task automatic sel();
    cs_n = 1'b0; tick(4);
  endtask

  task automatic desel();
    tick(4); cs_n = 1'b1; tick(8);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    sel(); xfer(op, d); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    sel(); xfer(8'h05, d); xfer(8'h00, s); desel();
  endtask

  task automatic wait_idle();
    logic [7:0] d;
    sel(); xfer(8'h05, d);
    for (int k = 0; k < 200; k++) begin
      xfer(8'h00, d);
      if (!d[0]) break;
    end
    desel();
  endtask

  task automatic wr_n(input logic [15:0] a, input logic [7:0] d0, d1, d2, input int n);
    logic [7:0] d;
    sel(); xfer(8'h02, d); xfer(a[15:8], d); xfer(a[7:0], d);
    xfer(d0, d);
    if (n > 1) xfer(d1, d);
    if (n > 2) xfer(d2, d);
    desel();
  endtask

  task automatic rd2(input logic [15:0] a, output logic [7:0] q0, q1);
    logic [7:0] d;
    sel(); xfer(8'h03, d); xfer(a[15:8], d); xfer(a[7:0], d);
    xfer(8'h00, q0); xfer(8'h00, q1); desel();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    sel(); xfer(8'h01, d); xfer(v, d); desel();
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    nchk = 0; nfail = 0; finished = 1'b0;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0;
    tick(5);
    check("R1 oe in reset", {7'd0, so_oe}, 8'h00);
    rst_n = 1'b1; tick(6);
    rdsr(st); check("R1 status after reset", st, 8'h00);
    check("R1 oe deselected", {7'd0, so_oe}, 8'h00);
    sel(); check("R11 oe selected", {7'd0, so_oe}, 8'h01); desel();

    // R2 write-enable flag
    cmd1(8'h06); rdsr(st); check("R2 wren", st, 8'h02);
    cmd1(8'h04); rdsr(st); check("R2 wrdi", st, 8'h00);

    // vector table: arm, write, wait, read back (R4 R6)
    for (int v = 0; v < 8; v++) begin
      cmd1(8'h06);
      wr_n(VEC[v][23:8], VEC[v][7:0], 8'h00, 8'h00, 1);
      wait_idle();
      rd2(VEC[v][23:8], r0, r1);
      check("R6 write then R4 read", r0, VEC[v][7:0]);
    end

    // R4 upper nibble ignored and sequential read
    rd2(16'h0123, r0, r1); check("R4 upper bits ignored", r0, 8'h0F);
    rd2(16'h0000, r0, r1);
    check("R4 seq first", r0, 8'h3C); check("R4 seq second", r1, 8'hA5);
    // R5 wrap
    rd2(16'h0FFF, r0, r1);
    check("R5 top byte", r0, 8'h5A); check("R5 wrap to zero", r1, 8'h3C);

    // R6 write without enable
    wr_n(16'h0001, 8'hEE, 8'h00, 8'h00, 1);
    rdsr(st); check("R6 no commit without enable", st, 8'h00);
    rd2(16'h0001, r0, r1); check("R6 array unchanged", r0, 8'hA5);

    // R7 page wrap
    cmd1(8'h06); wr_n(16'h005E, 8'h11, 8'h22, 8'h33, 3); wait_idle();
    rd2(16'h005E, r0, r1);
    check("R7 offset 30", r0, 8'h11); check("R7 offset 31", r1, 8'h22);
    rd2(16'h0040, r0, r1); check("R7 wrapped to offset 0", r0, 8'h33);

    // R8 chip select mid-byte
    cmd1(8'h06);
    sel(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h01, d); xfer(8'h77, d);
    for (int i = 0; i < 3; i++) begin
      si = 1'b1; tick(4); sck = 1'b1; tick(4); sck = 1'b0;
    end
    desel();
    rdsr(st); check("R8 enable kept no busy", st, 8'h02);
    rd2(16'h0001, r0, r1); check("R8 array unchanged", r0, 8'hA5);
    cmd1(8'h04);

    // R10 busy window
    wr_n(16'h0200, 8'h44, 8'h00, 8'h00, 1);
    cmd1(8'h06); wr_n(16'h0200, 8'h44, 8'h00, 8'h00, 1);
    rdsr(st); check("R10 busy set, enable cleared", st, 8'h01);
    cmd1(8'h06);
    wait_idle();
    rdsr(st); check("R10 enable ignored while busy", st, 8'h00);
    rd2(16'h0200, r0, r1); check("R10 data committed", r0, 8'h44);

    // R3 status writes
    wrsr(8'h0C); rdsr(st); check("R3 ignored without enable", st, 8'h00);
    cmd1(8'h06); wrsr(8'hF4); wait_idle();
    rdsr(st); check("R3 status written", st, 8'h34);

    // R9 zone 01
    cmd1(8'h06); wr_n(16'h0BFF, 8'h01, 8'h00, 8'h00, 1); wait_idle();
    cmd1(8'h06); wr_n(16'h0C00, 8'h02, 8'h00, 8'h00, 1); wait_idle();
    rd2(16'h0BFF, r0, r1);
    check("R9 code01 open", r0, 8'h01); check("R9 code01 locked", r1, 8'hF0);
    // zone 10
    cmd1(8'h06); wrsr(8'h08); wait_idle();
    rdsr(st); check("R9 code10 set", st, 8'h08);
    cmd1(8'h06); wr_n(16'h07FF, 8'h03, 8'h00, 8'h00, 1); wait_idle();
    cmd1(8'h06); wr_n(16'h0800, 8'h04, 8'h00, 8'h00, 1); wait_idle();
    rd2(16'h07FF, r0, r1);
    check("R9 code10 open", r0, 8'h03); check("R9 code10 locked", r1, 8'h96);
    // zone 11
    cmd1(8'h06); wrsr(8'h0C); wait_idle();
    cmd1(8'h06); wr_n(16'h0000, 8'h05, 8'h00, 8'h00, 1); wait_idle();
    rd2(16'h0000, r0, r1); check("R9 code11 locked", r0, 8'h3C);
    cmd1(8'h06); wrsr(8'h00); wait_idle();
    rdsr(st); check("R3 status cleared again", st, 8'h00);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule